// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Store Controller

This block is a register-mapped controller for a small byte-addressable store. A processor reaches it through a plain register bus: a 2-bit register select, 8-bit write data, a write strobe, and combinational read data. Four registers are visible. The address register (select 0) picks a byte. The data register (select 1) holds the byte to write or the result of a read. The control register (select 2) holds the read, write, write-enable, error and write-done bits. The unlock register (select 3) can only be written and always reads as zero.

A read copies the addressed byte into the data register. A write only starts after a fixed handshake: 0x55 then 0xAA to the unlock register, and then, as the next control write, the write bit with write-enable already set. A timed write cycle follows. It commits the byte and raises a done flag, which also drives the interrupt output.

Top module: `nvstore_ctrl`

## Requirements
- R1: After reset, the address, data and control registers read 0x00 and `irq` is low.
- R2: Writing the control register with bit 0 (read) set, while no write is running, loads the data register with the byte at the current address by the following clock edge. Bit 0 reads 1 for exactly one cycle and then clears itself.
- R3: The data register keeps its value when the address register changes. It changes only on another read or on a software write to select 1.
- R4: The control register has these bits: bit 1 is write, bit 2 is write-enable, bit 3 is error and bit 4 is done. The sequence is 0x55 to select 3, then 0xAA to select 3, then a control write with bit 1 set. After it, bit 1 reads 1 for exactly WCYC cycles and then clears. The byte is stored, and done is set.
- R5: Any other order is an error, and no write starts. Examples are a wrong unlock value, the two values reversed, or a write to another register between the steps. A control write with bit 1 set that is refused sets the error bit (bit 3).
- R6: The write bit cannot be set unless write-enable was already 1 before that control write. Setting both bits in the same write is refused.
- R7: Hardware never clears write-enable. Clearing it while a write is running neither aborts nor shortens that write.
- R8: The done bit stays set until software writes 1 to bit 4. Writing 1 to bit 3 clears the error bit. `irq` equals the done bit.
- R9: The unlock is consumed by the very next control write, even one without bit 1. It also expires when no write arrives within ARM_WIN cycles after the 0xAA write.
- R10: During a write, changes to the address and data registers do not change the byte or the location being written.
- R11: A read request made while a write is running is ignored. The read bit stays 0 and the data register is unchanged.
- R12: A write attempted within HOLDOFF cycles after reset is refused and sets the error bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 unlock |
| wdata | input | 8 | Bus write data |
| wen | input | 1 | Bus write strobe |
| rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Write-done interrupt (the done bit) |

## Verification
The assertions check properties that hold on every cycle. The read bit never stays high for two cycles. A read cannot register while a write is running. A write only begins when write-enable was set and the hold-off has ended. The end of a write always raises done. Done and write-enable survive every cycle without a software write. The latched target address stays stable during a write. Other behaviour needs a whole bus sequence and is left to the bench scenarios. This covers the exact unlock order and its rejections, the expiry and consumption of the unlock, the write length and the stored byte. It also covers resistance to corruption from register changes during a write, and the refusal during the hold-off.

// File: rtl/nvstore_ctrl.sv
module nvstore_ctrl #(
  parameter int ADDR_W  = 7,
  parameter int WCYC    = 20,
  parameter int ARM_WIN = 4,
  parameter int HOLDOFF = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_sel,
  input  logic [7:0] wdata,
  input  logic       wen,
  output logic [7:0] rdata,
  output logic       irq
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW = $clog2(WCYC + 1);
  localparam int HW = $clog2(HOLDOFF + 1);
  localparam int AW = $clog2(ARM_WIN + 1);

  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_ARMED} ul_t;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] addr_q, wa_q;
  logic [7:0]        data_q, wd_q;
  logic              rd_q, wr_q, wen_q, err_q, done_q;
  logic [CW-1:0]     cnt_q;
  logic [HW-1:0]     hold_q;
  logic [AW-1:0]     arm_q;
  ul_t               ul_q;

  wire ctrl_wr = wen && reg_sel == 2'd2;
  wire req_wr  = ctrl_wr && wdata[1];
  wire start   = req_wr && wen_q && ul_q == UL_ARMED && hold_q == '0 && !wr_q;
  wire finish  = wr_q && cnt_q == '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ul_q  <= UL_IDLE;
      arm_q <= '0;
    end else if (wen) begin
      if (reg_sel == 2'd3 && wdata == 8'h55 && ul_q == UL_IDLE)
        ul_q <= UL_HALF;
      else if (reg_sel == 2'd3 && wdata == 8'hAA && ul_q == UL_HALF) begin
        ul_q  <= UL_ARMED;
        arm_q <= AW'(ARM_WIN - 1);
      end else
        ul_q <= UL_IDLE;
    end else if (ul_q == UL_ARMED) begin
      if (arm_q == '0) ul_q <= UL_IDLE;
      else arm_q <= arm_q - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hold_q <= HW'(HOLDOFF);
    else if (hold_q != '0) hold_q <= hold_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_q <= '0; data_q <= '0; wa_q <= '0; wd_q <= '0; cnt_q <= '0;
      rd_q <= 1'b0; wr_q <= 1'b0; wen_q <= 1'b0; err_q <= 1'b0; done_q <= 1'b0;
    end else begin
      rd_q <= ctrl_wr && wdata[0] && !wr_q;
      if (wen && reg_sel == 2'd0) addr_q <= wdata[ADDR_W-1:0];
      if (rd_q) data_q <= mem[addr_q];
      else if (wen && reg_sel == 2'd1) data_q <= wdata;
      if (ctrl_wr) wen_q <= wdata[2];
      if (ctrl_wr && wdata[3]) err_q <= 1'b0;
      if (req_wr && !start && !wr_q) err_q <= 1'b1;
      if (ctrl_wr && wdata[4]) done_q <= 1'b0;
      if (finish) done_q <= 1'b1;
      if (start) begin
        wr_q  <= 1'b1;
        wa_q  <= addr_q;
        wd_q  <= data_q;
        cnt_q <= CW'(WCYC - 1);
      end else if (finish)
        wr_q <= 1'b0;
      else if (wr_q)
        cnt_q <= cnt_q - 1'b1;
    end

  always_ff @(posedge clk)
    if (finish) mem[wa_q] <= wd_q;

  always_comb
    case (reg_sel)
      2'd0:    rdata = 8'(addr_q);
      2'd1:    rdata = data_q;
      2'd2:    rdata = {3'b000, done_q, err_q, wen_q, wr_q, rd_q};
      default: rdata = 8'h00;
    endcase

  assign irq = done_q;

  a_r2_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n) rd_q |=> !rd_q);
  a_r11_no_rd_busy: assert property (@(posedge clk) disable iff (!rst_n) wr_q |=> !rd_q);
  a_r6_start_wen: assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_q) |-> $past(wen_q));
  a_r12_holdoff: assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_q) |-> $past(hold_q == '0));
  a_r4_done_at_end: assert property (@(posedge clk) disable iff (!rst_n) $fell(wr_q) |-> done_q);
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !ctrl_wr) |=> done_q);
  a_r7_wen_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_q && !ctrl_wr) |=> wen_q);
  a_r10_target_stable: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> $stable(wa_q) && $stable(wd_q));
endmodule

// File: tb/test_nvstore_ctrl.sv
module test_nvstore_ctrl;
  localparam int WCYC = 20;
  localparam int ARM_WIN = 4;
  localparam int HOLDOFF = 64;

  logic clk = 1'b0, rst_n = 1'b0, wen = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  nvstore_ctrl #(.ADDR_W(7), .WCYC(WCYC), .ARM_WIN(ARM_WIN), .HOLDOFF(HOLDOFF)) i_nvstore_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wdata(wdata), .wen(wen),
    .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; wdata = d; wen = 1'b1;
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic rr(input logic [1:0] s, output logic [7:0] v);
    reg_sel = s; #1; v = rdata;
  endtask

  task automatic unlock();
    bw(3, 8'h55); bw(3, 8'hAA);
  endtask

  task automatic wait_wr(output int n);
    logic [7:0] v;
    n = 0; rr(2, v);
    while (v[1] && n < 1000) begin n++; @(negedge clk); rr(2, v); end
  endtask

  task automatic rd_byte(input logic [7:0] a, output logic [7:0] v);
    bw(0, a); bw(2, 8'h01); @(negedge clk); rr(1, v);
  endtask

  task automatic full_write(input logic [7:0] a, input logic [7:0] d, output int n);
    bw(0, a); bw(1, d); bw(2, 8'h04); unlock(); bw(2, 8'h06); wait_wr(n);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int s = 0; s < 3; s++) begin rr(2'(s), v); chk(v == 0, "R1 reg after reset", v, 0); end
    chk(irq == 0, "R1 irq after reset", irq, 0);
  endtask

  task automatic t_holdoff();
    logic [7:0] v;
    bw(0, 8'd5); bw(1, 8'h11); bw(2, 8'h04); unlock(); bw(2, 8'h06);
    rr(2, v);
    chk(v[1] == 0, "R12 write blocked in holdoff", v[1], 0);
    chk(v[3] == 1, "R12 error set", v[3], 1);
    bw(2, 8'h08); rr(2, v);
    chk(v[3] == 0, "R8 error cleared by W1C", v[3], 0);
    repeat (HOLDOFF + 4) @(negedge clk);
  endtask

  task automatic t_write_read();
    logic [7:0] v; int n;
    full_write(8'd3, 8'hA5, n);
    chk(n == WCYC, "R4 write length", n, WCYC);
    rr(2, v);
    chk(v[4] == 1 && irq == 1, "R4 done set", v, 8'h14);
    chk(v[2] == 1, "R7 wen kept after write", v[2], 1);
    bw(2, 8'h10);
    bw(0, 8'd3); bw(2, 8'h01); rr(2, v);
    chk(v[0] == 1, "R2 read bit set", v[0], 1);
    @(negedge clk); rr(2, v);
    chk(v[0] == 0, "R2 read bit self clears", v[0], 0);
    rr(1, v);
    chk(v == 8'hA5, "R2 read data", v, 8'hA5);
    bw(0, 8'd40); rr(1, v);
    chk(v == 8'hA5, "R3 data kept on addr change", v, 8'hA5);
    bw(1, 8'h33); rr(1, v);
    chk(v == 8'h33, "R3 data sw write", v, 8'h33);
  endtask

  task automatic bad_try(input int kind, input string tag);
    logic [7:0] v;
    bw(0, 8'd3); bw(1, 8'h5A); bw(2, 8'h04);
    case (kind)
      0: begin bw(3, 8'h55); bw(3, 8'hAB); end
      1: begin bw(3, 8'hAA); bw(3, 8'h55); end
      2: begin bw(3, 8'h55); bw(0, 8'd3); bw(3, 8'hAA); end
      3: begin bw(3, 8'h55); bw(3, 8'h55); bw(3, 8'hAA); end
      4: begin unlock(); repeat (ARM_WIN + 2) @(negedge clk); end
      default: begin unlock(); bw(2, 8'h04); end
    endcase
    bw(2, 8'h06); rr(2, v);
    chk(v[1] == 0 && v[3] == 1, tag, v, 8'h0C);
    bw(2, 8'h08);
    rd_byte(8'd3, v);
    chk(v == 8'hA5, {tag, " byte intact"}, v, 8'hA5);
  endtask

  task automatic t_wen_rule();
    logic [7:0] v;
    bw(0, 8'd3); bw(1, 8'h5A); bw(2, 8'h00); unlock(); bw(2, 8'h06); rr(2, v);
    chk(v[1] == 0 && v[3] == 1, "R6 wr needs prior wen", v, 8'h0C);
    bw(2, 8'h08); rd_byte(8'd3, v);
    chk(v == 8'hA5, "R6 byte intact", v, 8'hA5);
  endtask

  task automatic t_wen_clear_during();
    logic [7:0] v; int n;
    bw(0, 8'd10); bw(1, 8'h6E); bw(2, 8'h04); unlock(); bw(2, 8'h06);
    bw(2, 8'h00); rr(2, v);
    chk(v[2] == 0 && v[1] == 1, "R7 wen cleared, write runs", v, 8'h02);
    wait_wr(n);
    chk(n == WCYC - 2, "R7 write not shortened", n, WCYC - 2);
    bw(2, 8'h10); rd_byte(8'd10, v);
    chk(v == 8'h6E, "R7 byte stored", v, 8'h6E);
  endtask

  task automatic t_corrupt_and_read();
    logic [7:0] v; int n;
    bw(0, 8'd7); bw(1, 8'h3C); bw(2, 8'h04); unlock(); bw(2, 8'h06);
    bw(0, 8'd3); bw(1, 8'h77); bw(2, 8'h05); rr(2, v);
    chk(v[0] == 0, "R11 read ignored in write", v[0], 0);
    @(negedge clk); rr(1, v);
    chk(v == 8'h77, "R11 data unchanged", v, 8'h77);
    wait_wr(n);
    rr(2, v);
    chk(v[4] == 1, "R8 done after write", v[4], 1);
    bw(2, 8'h04); rr(2, v);
    chk(v[4] == 1 && irq == 1, "R8 done sticky", v[4], 1);
    bw(2, 8'h14); rr(2, v);
    chk(v[4] == 0 && irq == 0, "R8 done W1C", v[4], 0);
    rd_byte(8'd7, v);
    chk(v == 8'h3C, "R10 byte not corrupted", v, 8'h3C);
    rd_byte(8'd3, v);
    chk(v == 8'hA5, "R10 other location untouched", v, 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_holdoff();
    t_write_read();
    bad_try(0, "R5 wrong second value");
    bad_try(1, "R5 reversed order");
    bad_try(2, "R5 access between steps");
    bad_try(3, "R5 repeated first value");
    bad_try(4, "R9 unlock expired");
    bad_try(5, "R9 unlock consumed by ctrl write");
    t_wen_rule();
    t_wen_clear_during();
    t_corrupt_and_read();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule